// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block lets an 8-bit processor with a 16-bit address bus reach a ROM of up to 2MB and a battery-backed RAM of up to 32KB. The low 32KB of the processor's address space is a ROM window. Its lower half always shows ROM bank 0. Its upper half shows one switchable 16KB bank. A separate 8KB window at 0xA000-0xBFFF shows one of four RAM banks. The ROM cannot be written, so any processor write below 0x8000 is taken as a write to one of four control registers. Bits 14:13 of the address pick the register, in this order: RAM unlock, low ROM bank, shared 2-bit bank field, mode.

The controller produces the physical ROM address, the physical RAM address and the RAM chip-enable and write-enable strobes. It also returns read data to the processor. The mode bit decides what the shared 2-bit field is used for. It either extends the ROM bank number or selects the RAM bank. While the RAM is locked, its window reads as 0xFF and writes to it are dropped.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset, the switchable window shows ROM bank 1, RAM is locked, the RAM bank is 0 and the mode is ROM mode (mode bit 0).
- R2: A CPU address in 0x0000-0x3FFF gives rom_addr = {7'b0, cpu_addr[13:0]}, whatever the register contents.
- R3: A CPU address in 0x4000-0x7FFF gives rom_addr = {bank[6:0], cpu_addr[13:0]}. In ROM mode bank[4:0] comes from the low bank register and bank[6:5] from the shared field.
- R4: A write to 0x2000-0x3FFF stores cpu_wdata[4:0] in the low bank register. A stored value of 0 selects bank field 1, so the switchable window never shows a low field of 0.
- R5: A write to 0x0000-0x1FFF unlocks the RAM when cpu_wdata[3:0] equals 4'hA, whatever the upper nibble holds. Any other low nibble locks it.
- R6: While the RAM is locked, an access to 0xA000-0xBFFF keeps ram_ce and ram_we low and returns 0xFF on cpu_rdata. A write attempted in this state leaves the RAM contents unchanged.
- R7: While the RAM is unlocked, an access to 0xA000-0xBFFF raises ram_ce and drives ram_addr = {ram_bank[1:0], cpu_addr[12:0]}. ram_we follows cpu_wr, and cpu_rdata returns ram_rdata.
- R8: A write to 0x6000-0x7FFF stores cpu_wdata[0] as the mode bit. With mode 1, the shared field (written at 0x4000-0x5FFF, data bits 1:0) is the RAM bank and ROM bank bits 6:5 are 0. With mode 0, the RAM bank is 0.
- R9: CPU writes at 0x8000 and above change no control register.
- R10: cpu_rdata returns rom_rdata for addresses 0x0000-0x7FFF and 0xFF for addresses outside both the ROM and RAM windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe for the current cycle |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_rdata | input | 8 | RAM read data |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |

## Verification
Some properties are checked on every cycle:
- unlocking and locking of the RAM by the written nibble;
- control registers that hold still when no register write occurs;
- the fixed window that always maps to bank 0;
- a switchable low field that is never zero;
- a RAM bank of zero in ROM mode;
- open-bus reads outside the mapped windows.

Only the bench scenarios can show the full bank arithmetic after register sequences, because the result depends on which registers were written before. The same holds for the swap of the shared field between ROM and RAM use when the mode changes, for the dropping of writes to a locked RAM, and for the return to bank 1 after a reset in the middle of a run.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;
    localparam int LO_BANK_W = 5;
    localparam int SH_BANK_W = 2;
    localparam int ROM_OFS_W = 14;
    localparam int RAM_OFS_W = 13;

    localparam int ROM_BANK_W = LO_BANK_W + SH_BANK_W;
    localparam int ROM_PA_W   = ROM_OFS_W + ROM_BANK_W;
    localparam int RAM_PA_W   = RAM_OFS_W + SH_BANK_W;

    localparam logic [3:0]        RAM_KEY  = 4'hA;
    localparam logic [CPU_DW-1:0] OPEN_BUS = '1;

    // Address-bit 14:13 order is behaviour: it selects the register.
    typedef enum logic [1:0] {
        SEL_UNLOCK = 2'd0,
        SEL_LOBANK = 2'd1,
        SEL_SHARED = 2'd2,
        SEL_MODE   = 2'd3
    } ctl_sel_e;

    typedef enum logic [1:0] {
        RG_OTHER,
        RG_ROM_FIXED,
        RG_ROM_SWITCH,
        RG_EXT_RAM
    } region_e;

    typedef struct packed {
        logic                 ram_on;
        logic [LO_BANK_W-1:0] lo_bank;
        logic [SH_BANK_W-1:0] shared;
        logic                 ram_mode;
    } bank_regs_t;

    function automatic region_e decode_region(input logic [CPU_AW-1:0] a);
        if (a[15:14] == 2'b00)      return RG_ROM_FIXED;
        else if (a[15:14] == 2'b01) return RG_ROM_SWITCH;
        else if (a[15:13] == 3'b101) return RG_EXT_RAM;
        else                         return RG_OTHER;
    endfunction

    function automatic logic [LO_BANK_W-1:0] lift_zero(input logic [LO_BANK_W-1:0] v);
        return (v == '0) ? LO_BANK_W'(1) : v;
    endfunction

endpackage

// File: rtl/cbc_ctl_regs.sv
module cbc_ctl_regs
    import cbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  ctl_sel_e             sel,
    input  logic [LO_BANK_W-1:0] wdata,
    output bank_regs_t           regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_UNLOCK: regs.ram_on   <= (wdata[3:0] == RAM_KEY);
                SEL_LOBANK: regs.lo_bank  <= wdata;
                SEL_SHARED: regs.shared   <= wdata[SH_BANK_W-1:0];
                SEL_MODE:   regs.ram_mode <= wdata[0];
                default:    regs          <= regs;
            endcase
        end
    end

    assert_reset_R1: assert property (@(posedge clk) rst |=> regs == '0);

    assert_unlock_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_UNLOCK && wdata[3:0] == RAM_KEY) |=> regs.ram_on);

    assert_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_UNLOCK && wdata[3:0] != RAM_KEY) |=> !regs.ram_on);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/cbc_bank_map.sv
module cbc_bank_map
    import cbc_pkg::*;
(
    input  logic [CPU_AW-1:0]   addr,
    input  bank_regs_t          regs,
    output region_e             region,
    output logic [ROM_PA_W-1:0] rom_pa,
    output logic [RAM_PA_W-1:0] ram_pa
);

    logic [SH_BANK_W-1:0]  rom_hi;
    logic [SH_BANK_W-1:0]  ram_bank;
    logic [ROM_BANK_W-1:0] rom_bank;

    always_comb begin
        region   = decode_region(addr);
        rom_hi   = regs.ram_mode ? '0 : regs.shared;
        ram_bank = regs.ram_mode ? regs.shared : '0;
        rom_bank = (region == RG_ROM_FIXED) ? '0 : {rom_hi, lift_zero(regs.lo_bank)};
        rom_pa   = {rom_bank, addr[ROM_OFS_W-1:0]};
        ram_pa   = {ram_bank, addr[RAM_OFS_W-1:0]};
    end

    always_comb begin
        if (!$isunknown({addr, regs})) begin
            if (addr[15:14] == 2'b00)
                assert_bank0_R2: assert (rom_pa[ROM_PA_W-1:ROM_OFS_W] == '0);
            if (addr[15:14] == 2'b01)
                assert_lo_nonzero_R4: assert (rom_pa[ROM_OFS_W +: LO_BANK_W] != '0);
            if (!regs.ram_mode)
                assert_rambank_rommode_R8: assert (ram_pa[RAM_PA_W-1:RAM_OFS_W] == '0);
        end
    end

endmodule

// File: rtl/cbc_read_mux.sv
module cbc_read_mux
    import cbc_pkg::*;
(
    input  region_e           region,
    input  logic              ram_on,
    input  logic [CPU_DW-1:0] rom_rdata,
    input  logic [CPU_DW-1:0] ram_rdata,
    output logic [CPU_DW-1:0] rdata
);

    always_comb begin
        case (region)
            RG_ROM_FIXED, RG_ROM_SWITCH: rdata = rom_rdata;
            RG_EXT_RAM:                  rdata = ram_on ? ram_rdata : OPEN_BUS;
            default:                     rdata = OPEN_BUS;
        endcase
    end

    always_comb begin
        if (!$isunknown({region, ram_on}) && region == RG_EXT_RAM && !ram_on)
            assert_locked_read_R6: assert (rdata == OPEN_BUS);
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [CPU_DW-1:0]    cpu_wdata,
    input  logic                 cpu_wr,
    output logic [CPU_DW-1:0]    cpu_rdata,
    output logic [ROM_PA_W-1:0]  rom_addr,
    input  logic [CPU_DW-1:0]    rom_rdata,
    output logic [RAM_PA_W-1:0]  ram_addr,
    input  logic [CPU_DW-1:0]    ram_rdata,
    output logic                 ram_ce,
    output logic                 ram_we
);

    bank_regs_t regs;
    region_e    region;
    logic       ctl_wr;
    ctl_sel_e   ctl_sel;

    assign ctl_wr  = cpu_wr && !cpu_addr[15];
    assign ctl_sel = ctl_sel_e'(cpu_addr[14:13]);

    cbc_ctl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctl_wr),
        .sel   (ctl_sel),
        .wdata (cpu_wdata[LO_BANK_W-1:0]),
        .regs  (regs)
    );

    cbc_bank_map u_map (
        .addr   (cpu_addr),
        .regs   (regs),
        .region (region),
        .rom_pa (rom_addr),
        .ram_pa (ram_addr)
    );

    cbc_read_mux u_rmux (
        .region    (region),
        .ram_on    (regs.ram_on),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rdata     (cpu_rdata)
    );

    assign ram_ce = (region == RG_EXT_RAM) && regs.ram_on;
    assign ram_we = ram_ce && cpu_wr;

    assert_we_gated_R6: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_addr[15:13] == 3'b101 && cpu_wr));

endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [20:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [14:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic        ram_ce;
    logic        ram_we;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cart_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_ce(ram_ce), .ram_we(ram_we)
    );

    // ROM model: content derived from the physical address.
    assign rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};

    // Small RAM model: bank bits plus low 4 offset bits.
    logic [7:0] ram_mem [0:63];
    assign ram_rdata = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];
    initial for (int i = 0; i < 64; i++) ram_mem[i] = 8'h00;
    always @(posedge clk) if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= cpu_wdata;

    localparam logic [1:0] K_WR = 2'd0, K_ROM = 2'd1, K_RAM = 2'd2, K_RD = 2'd3;
    localparam int NV = 29;
    // {req[3:0], kind[1:0], addr[15:0], data[7:0], expected[23:0]}
    localparam logic [53:0] VEC [0:NV-1] = '{
        {4'd1,  K_ROM, 16'h4000, 8'h00, 24'h004000}, // R1 bank 1 after reset
        {4'd1,  K_RAM, 16'hA000, 8'h00, 24'h000000}, // R1 locked, bank 0
        {4'd2,  K_ROM, 16'h0123, 8'h00, 24'h000123}, // R2
        {4'd4,  K_WR,  16'h2000, 8'h05, 24'h0},
        {4'd3,  K_ROM, 16'h4010, 8'h00, 24'h014010}, // R3 bank 5
        {4'd4,  K_WR,  16'h2000, 8'h00, 24'h0},
        {4'd4,  K_ROM, 16'h7FFF, 8'h00, 24'h007FFF}, // R4 zero -> 1
        {4'd4,  K_WR,  16'h3FFF, 8'hE0, 24'h0},
        {4'd4,  K_ROM, 16'h4000, 8'h00, 24'h004000}, // R4 upper bits ignored
        {4'd3,  K_WR,  16'h2000, 8'h1F, 24'h0},
        {4'd3,  K_WR,  16'h4000, 8'h03, 24'h0},
        {4'd3,  K_ROM, 16'h4000, 8'h00, 24'h1FC000}, // R3 bank 0x7F
        {4'd2,  K_ROM, 16'h0000, 8'h00, 24'h000000}, // R2 still bank 0
        {4'd5,  K_WR,  16'h0000, 8'h0A, 24'h0},
        {4'd8,  K_RAM, 16'hA123, 8'h00, 24'h008123}, // R8 rom mode ram bank 0
        {4'd8,  K_WR,  16'h6000, 8'h01, 24'h0},
        {4'd8,  K_RAM, 16'hB456, 8'h00, 24'h00F456}, // R8 ram bank 3
        {4'd8,  K_ROM, 16'h4000, 8'h00, 24'h07C000}, // R8 rom hi bits 0
        {4'd7,  K_WR,  16'hA005, 8'h5A, 24'h0},
        {4'd7,  K_RD,  16'hA005, 8'h00, 24'h00005A}, // R7 read back
        {4'd5,  K_WR,  16'h0000, 8'h1A, 24'h0},
        {4'd5,  K_RD,  16'hA005, 8'h00, 24'h00005A}, // R5 high nibble ignored
        {4'd5,  K_WR,  16'h1FFF, 8'h0B, 24'h0},
        {4'd6,  K_RD,  16'hA005, 8'h00, 24'h0000FF}, // R6 locked read
        {4'd6,  K_RAM, 16'hA005, 8'h00, 24'h006005}, // R6 ce low
        {4'd6,  K_WR,  16'hA005, 8'h11, 24'h0},      // dropped write
        {4'd9,  K_WR,  16'hC000, 8'h00, 24'h0},      // R9 no register effect
        {4'd10, K_RD,  16'hC000, 8'h00, 24'h0000FF}, // R10 open bus
        {4'd10, K_RD,  16'h4005, 8'h00, 24'h00001A}  // R10 rom data
    };

    task automatic check(input int req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input int req, input logic [1:0] kind, input logic [15:0] a,
                         input logic [23:0] exp);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
        case (kind)
            K_ROM:   check(req, {3'b0, rom_addr}, exp);
            K_RAM:   check(req, {8'b0, ram_ce, ram_addr}, exp);
            default: check(req, {16'b0, cpu_rdata}, exp);
        endcase
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][49:48] == K_WR)
                do_write(VEC[i][47:32], VEC[i][31:24]);
            else
                probe(int'(VEC[i][53:50]), VEC[i][49:48], VEC[i][47:32], VEC[i][23:0]);
        end

        // R6: dropped write left RAM unchanged
        do_write(16'h0000, 8'h0A);
        probe(6, K_RD, 16'hA005, 24'h00005A);

        // R7: write strobe during an unlocked RAM write
        @(negedge clk);
        cpu_addr = 16'hA003; cpu_wdata = 8'h33; cpu_wr = 1'b1;
        #1;
        check(7, {22'b0, ram_ce, ram_we}, 24'h3);
        @(negedge clk);
        cpu_wr = 1'b0;
        probe(7, K_RD, 16'hA003, 24'h000033);

        // R9: write in video range leaves banks intact
        do_write(16'h8000, 8'h00);
        probe(9, K_ROM, 16'h4000, 24'h07C000);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        probe(1, K_ROM, 16'h4000, 24'h004000);
        probe(1, K_RAM, 16'hA000, 24'h000000);
        probe(1, K_RD,  16'hA000, 24'h0000FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule